// File: doc/BRIEF.md
# Configurable Programmable Logic Array

This block is a two-level sum-of-products array whose logic function is fully set by a configuration store. Each input is offered to the AND plane in its true and its inverted form, and each form has its own connection bit. A product term is the AND of the literals that are connected to it. There is a shared, limited set of product terms; they are not a full decode of every minterm. An OR plane then selects, for each output, which product terms are summed. A final polarity bit can invert each sum.

The configuration is written one row at a time through a word-wide port: an address, a data word and a write enable, sampled on the clock. It can be read back through an independent combinational read address. The evaluation path from the inputs to the outputs contains no registers. Outputs therefore follow the inputs within the same cycle, and they follow a configuration write from the edge that stores it.

The rows are laid out in this order. Rows `0 .. N_PT-1` hold the AND rows, one per product term. The next `N_OUT` rows hold the OR rows, one per output. The single row after those holds the polarity word. Every higher address is unmapped.

Top module: `pla_array`

## Requirements
- R1: While `rst_n` is low, every configuration bit is cleared. After reset, every output reads 0 for every input vector, and every row reads back as 0.
- R2: In AND row `p`, bit `2*i` connects the true form of input `i` and bit `2*i+1` connects its inverted form. Product term `p` is the AND of its connected literals. For example, row `8'b0000_1001` gives `in[0] & ~in[1]`.
- R3: A product term with no literal connected evaluates to 1.
- R4: A product term that connects both forms of the same input evaluates to 0 for every input vector.
- R5: Bit `j` of OR row `k` (address `N_PT+k`) connects product term `j` to output `k`. The sum is the OR of the connected terms, and a sum with no connected term is 0.
- R6: Bit `k` of the polarity row (address `N_PT+N_OUT`) set to 1 inverts output `k`. Set to 0, it passes the sum unchanged.
- R7: A write with `cfg_we` high stores `cfg_wdata` into the addressed row at the rising clock edge. Outputs reflect the new row from that edge on, and they respond to input changes with no clock edge.
- R8: Reading back a mapped row returns its stored bits. Data bits above the row's width are dropped on write and read back as 0.
- R9: A write to an address at or above `N_PT+N_OUT+1` changes no row, and a read from such an address returns 0.
- R10: With `cfg_we` low, no row changes, whatever values `cfg_addr` and `cfg_wdata` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for configuration writes |
| rst_n | input | 1 | Asynchronous active-low reset that clears the configuration |
| cfg_we | input | 1 | Write enable for one configuration row |
| cfg_addr | input | AW | Row address for writes |
| cfg_wdata | input | W | Row data for writes |
| cfg_raddr | input | AW | Row address for readback |
| cfg_rdata | output | W | Readback data for the row at `cfg_raddr` |
| in_vec | input | N_IN | Array inputs |
| out_vec | output | N_OUT | Array outputs after polarity |

## Verification
The default size has 4 inputs, 6 terms and 3 outputs. At this size every configuration the bench loads is checked against all 16 input vectors, with each expected output computed from a sum-of-products model kept in the bench.

The directed patterns each isolate one part of the array:
- A single two-literal term shows the bit order of the literals.
- An empty term shows the default of a product term with nothing connected.
- A term that connects both forms of one input shows the contradiction case.
- An empty OR row, tried with and without its polarity bit, separates the sum from the inverter.

Random configurations use sparse AND rows so that the product terms take both values. Their data words carry unused high bits, which shows that the truncation in the store matches the readback. Writes to unmapped addresses, and idle cycles with a changing address and data, show that no stray row is written.

// File: rtl/pla_pkg.sv
package pla_pkg;

    typedef enum logic [1:0] {
        SEC_AND  = 2'd0,
        SEC_OR   = 2'd1,
        SEC_POL  = 2'd2,
        SEC_NONE = 2'd3
    } pla_sec_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic pla_sec_e row_kind(input int row, input int n_pt, input int n_out);
        if (row < n_pt)
            return SEC_AND;
        else if (row < n_pt + n_out)
            return SEC_OR;
        else if (row == n_pt + n_out)
            return SEC_POL;
        else
            return SEC_NONE;
    endfunction

endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store
    import pla_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_PT  = 6,
    parameter int N_OUT = 3,
    parameter int W     = 8,
    parameter int AW    = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [AW-1:0]           cfg_addr,
    input  logic [W-1:0]            cfg_wdata,
    input  logic [AW-1:0]           cfg_raddr,
    output logic [W-1:0]            cfg_rdata,
    output logic [N_PT*2*N_IN-1:0]  and_flat,
    output logic [N_OUT*N_PT-1:0]   or_flat,
    output logic [N_OUT-1:0]        pol_bits
);

    localparam int AND_W   = 2 * N_IN;
    localparam int ROWS    = N_PT + N_OUT + 1;
    localparam int POL_ROW = N_PT + N_OUT;

    logic [AND_W-1:0] and_q [N_PT];
    logic [N_PT-1:0]  or_q  [N_OUT];
    logic [N_OUT-1:0] pol_q;

    pla_sec_e wr_kind;
    pla_sec_e rd_kind;

    assign wr_kind = row_kind(int'(cfg_addr), N_PT, N_OUT);
    assign rd_kind = row_kind(int'(cfg_raddr), N_PT, N_OUT);

    // One register row per product term
    for (genvar p = 0; p < N_PT; p++) begin : g_and_row
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                and_q[p] <= '0;
            else if (cfg_we && wr_kind == SEC_AND && cfg_addr == AW'(p))
                and_q[p] <= cfg_wdata[AND_W-1:0];
        end
        assign and_flat[p*AND_W +: AND_W] = and_q[p];
    end

    // One register row per output
    for (genvar k = 0; k < N_OUT; k++) begin : g_or_row
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                or_q[k] <= '0;
            else if (cfg_we && wr_kind == SEC_OR && cfg_addr == AW'(N_PT + k))
                or_q[k] <= cfg_wdata[N_PT-1:0];
        end
        assign or_flat[k*N_PT +: N_PT] = or_q[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pol_q <= '0;
        else if (cfg_we && wr_kind == SEC_POL)
            pol_q <= cfg_wdata[N_OUT-1:0];
    end
    assign pol_bits = pol_q;

    // Readback mux, zero-extended to the port width
    always_comb begin
        cfg_rdata = '0;
        unique case (rd_kind)
            SEC_AND: begin
                for (int p = 0; p < N_PT; p++)
                    if (cfg_raddr == AW'(p))
                        cfg_rdata = W'(and_q[p]);
            end
            SEC_OR: begin
                for (int k = 0; k < N_OUT; k++)
                    if (cfg_raddr == AW'(N_PT + k))
                        cfg_rdata = W'(or_q[k]);
            end
            SEC_POL:  cfg_rdata = W'(pol_q);
            SEC_NONE: cfg_rdata = '0;
        endcase
    end

    // R1
    cfg_reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (and_flat == '0 && or_flat == '0 && pol_q == '0));

    // R10
    cfg_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(and_flat) && $stable(or_flat) && $stable(pol_q)));

    // R9
    cfg_oor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && int'(cfg_addr) >= ROWS) |=> ($stable(and_flat) && $stable(or_flat) && $stable(pol_q)));

    // R9
    cfg_oor_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cfg_raddr) >= ROWS) |-> (cfg_rdata == '0));

    // R7
    cfg_pol_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == AW'(POL_ROW)) |=> (pol_q == $past(cfg_wdata[N_OUT-1:0])));

    // R8
    cfg_pol_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_raddr == AW'(POL_ROW)) |-> (cfg_rdata == W'(pol_q)));

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
    parameter int N_IN = 4,
    parameter int N_PT = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_IN-1:0]         in_vec,
    input  logic [N_PT*2*N_IN-1:0]  and_flat,
    output logic [N_PT-1:0]         terms
);

    localparam int AND_W = 2 * N_IN;

    logic [AND_W-1:0] lits;
    logic [AND_W-1:0] even_mask;

    // Interleave literals: true form at even bit, inverted at odd bit
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
        assign lits[2*i]        = in_vec[i];
        assign lits[2*i+1]      = ~in_vec[i];
        assign even_mask[2*i]   = 1'b1;
        assign even_mask[2*i+1] = 1'b0;
    end

    for (genvar p = 0; p < N_PT; p++) begin : g_term
        logic [AND_W-1:0] row;
        assign row      = and_flat[p*AND_W +: AND_W];
        // An unconnected literal is forced to 1 so it does not mask the term
        assign terms[p] = &(lits | ~row);

        // R4
        term_conflict_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (|(row & (row >> 1) & even_mask)) |-> !terms[p]);

        // R3
        term_empty_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (row == '0) |-> terms[p]);
    end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
    parameter int N_PT  = 6,
    parameter int N_OUT = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_PT-1:0]        terms,
    input  logic [N_OUT*N_PT-1:0]  or_flat,
    input  logic [N_OUT-1:0]       pol_bits,
    output logic [N_OUT-1:0]       out_vec
);

    logic [N_OUT-1:0] sums;

    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        logic [N_PT-1:0] sel;
        assign sel        = or_flat[k*N_PT +: N_PT];
        assign sums[k]    = |(sel & terms);
        assign out_vec[k] = sums[k] ^ pol_bits[k];

        // R5
        out_empty_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sel == '0) |-> (out_vec[k] == pol_bits[k]));

        // R6
        out_pol_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((sel & terms) != '0) |-> (out_vec[k] == !pol_bits[k]));
    end

endmodule

// File: rtl/pla_array.sv
module pla_array
    import pla_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_PT  = 6,
    parameter int N_OUT = 3,
    localparam int W    = max3(2 * N_IN, N_PT, N_OUT),
    localparam int ROWS = N_PT + N_OUT + 1,
    localparam int AW   = $clog2(ROWS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [W-1:0]     cfg_wdata,
    input  logic [AW-1:0]    cfg_raddr,
    output logic [W-1:0]     cfg_rdata,
    input  logic [N_IN-1:0]  in_vec,
    output logic [N_OUT-1:0] out_vec
);

    logic [N_PT*2*N_IN-1:0] and_flat;
    logic [N_OUT*N_PT-1:0]  or_flat;
    logic [N_OUT-1:0]       pol_bits;
    logic [N_PT-1:0]        terms;

    pla_cfg_store #(
        .N_IN (N_IN),
        .N_PT (N_PT),
        .N_OUT(N_OUT),
        .W    (W),
        .AW   (AW)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .cfg_raddr(cfg_raddr),
        .cfg_rdata(cfg_rdata),
        .and_flat (and_flat),
        .or_flat  (or_flat),
        .pol_bits (pol_bits)
    );

    pla_and_plane #(
        .N_IN(N_IN),
        .N_PT(N_PT)
    ) u_and (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vec  (in_vec),
        .and_flat(and_flat),
        .terms   (terms)
    );

    pla_or_plane #(
        .N_PT (N_PT),
        .N_OUT(N_OUT)
    ) u_or (
        .clk     (clk),
        .rst_n   (rst_n),
        .terms   (terms),
        .or_flat (or_flat),
        .pol_bits(pol_bits),
        .out_vec (out_vec)
    );

    // R1
    top_reset_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (out_vec == '0));

endmodule

// File: tb/pla_array_bench.sv
module pla_array_bench;

    localparam int NI   = 4;
    localparam int NP   = 6;
    localparam int NO   = 3;
    localparam int W    = 8;
    localparam int ROWS = NP + NO + 1;
    localparam int AW   = 4;
    localparam int POLR = NP + NO;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [W-1:0]  cfg_wdata = '0;
    logic [AW-1:0] cfg_raddr = '0;
    logic [W-1:0]  cfg_rdata;
    logic [NI-1:0] in_vec = '0;
    logic [NO-1:0] out_vec;

    int checks = 0;
    int failures = 0;

    logic [2*NI-1:0] sh_and [NP];
    logic [NP-1:0]   sh_or  [NO];
    logic [NO-1:0]   sh_pol;

    always #10 clk = ~clk;

    pla_array #(.N_IN(NI), .N_PT(NP), .N_OUT(NO)) u_pla_array (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
        .in_vec(in_vec), .out_vec(out_vec)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [NO-1:0] model(input logic [NI-1:0] x);
        logic [NP-1:0] t;
        logic [NO-1:0] o;
        for (int p = 0; p < NP; p++) begin
            t[p] = 1'b1;
            for (int i = 0; i < NI; i++) begin
                if (sh_and[p][2*i] && !x[i])  t[p] = 1'b0;
                if (sh_and[p][2*i+1] && x[i]) t[p] = 1'b0;
            end
        end
        for (int k = 0; k < NO; k++)
            o[k] = (|(sh_or[k] & t)) ^ sh_pol[k];
        return o;
    endfunction

    // Write one row; the store updates at the posedge inside this task
    task automatic wr(input int addr, input logic [W-1:0] data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = AW'(addr);
        cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        if (addr < NP)              sh_and[addr]    = data[2*NI-1:0];
        else if (addr < NP + NO)    sh_or[addr-NP]  = data[NP-1:0];
        else if (addr == POLR)      sh_pol          = data[NO-1:0];
    endtask

    function automatic logic [W-1:0] shadow_row(input int r);
        if (r < NP)           return W'(sh_and[r]);
        else if (r < NP + NO) return W'(sh_or[r-NP]);
        else if (r == POLR)   return W'(sh_pol);
        else                  return '0;
    endfunction

    task automatic sweep(input string tag);
        for (int v = 0; v < (1 << NI); v++) begin
            in_vec = NI'(v);
            #1;
            check(out_vec == model(NI'(v)), tag, 32'(out_vec), 32'(model(NI'(v))));
        end
    endtask

    task automatic readback_all(input string tag);
        for (int r = 0; r < (1 << AW); r++) begin
            cfg_raddr = AW'(r);
            #1;
            check(cfg_rdata == shadow_row(r), tag, 32'(cfg_rdata), 32'(shadow_row(r)));
        end
    endtask

    task automatic clear_all();
        for (int r = 0; r < ROWS; r++) wr(r, '0);
    endtask

    initial begin
        for (int p = 0; p < NP; p++) sh_and[p] = '0;
        for (int k = 0; k < NO; k++) sh_or[k] = '0;
        sh_pol = '0;
        repeat (3) @(negedge clk);
        // Garbage on the write port during reset must not survive it
        cfg_we = 1'b1; cfg_addr = 4'd2; cfg_wdata = 8'hFF;
        @(negedge clk);
        cfg_we = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R1: all-zero configuration after reset
        for (int v = 0; v < (1 << NI); v++) begin
            in_vec = NI'(v);
            #1;
            check(out_vec == '0, "R1 outputs after reset", 32'(out_vec), 0);
        end
        readback_all("R1 readback after reset");

        // R2: term0 = in[0] & ~in[1], routed to output 0
        wr(0, 8'b0000_1001);
        wr(NP + 0, 8'b0000_0001);
        for (int v = 0; v < (1 << NI); v++) begin
            in_vec = NI'(v);
            #1;
            check(out_vec[0] == (in_vec[0] & ~in_vec[1]), "R2 literal order",
                  32'(out_vec[0]), 32'(in_vec[0] & ~in_vec[1]));
        end

        // R3: empty term1 routed to output 1 gives constant 1
        wr(NP + 1, 8'b0000_0010);
        for (int v = 0; v < (1 << NI); v++) begin
            in_vec = NI'(v);
            #1;
            check(out_vec[1] == 1'b1, "R3 empty term", 32'(out_vec[1]), 1);
        end

        // R4: term2 uses both forms of in[0]; only term2 on output 1
        wr(2, 8'b0000_0011);
        wr(NP + 1, 8'b0000_0100);
        for (int v = 0; v < (1 << NI); v++) begin
            in_vec = NI'(v);
            #1;
            check(out_vec[1] == 1'b0, "R4 contradicting term", 32'(out_vec[1]), 0);
        end

        // R5: output 2 has an empty OR row
        sweep("R5 empty sum");
        in_vec = 4'h5; #1;
        check(out_vec[2] == 1'b0, "R5 empty sum is zero", 32'(out_vec[2]), 0);

        // R6: polarity on output 2 and output 0
        wr(POLR, 8'b0000_0101);
        for (int v = 0; v < (1 << NI); v++) begin
            in_vec = NI'(v);
            #1;
            check(out_vec[2] == 1'b1, "R6 inverted empty sum", 32'(out_vec[2]), 1);
            check(out_vec[0] == ~(in_vec[0] & ~in_vec[1]), "R6 inverted term",
                  32'(out_vec[0]), 32'(~(in_vec[0] & ~in_vec[1])));
        end

        // R7: inputs act without a clock edge
        @(negedge clk);
        in_vec = 4'b0001; #1;
        check(out_vec[0] == 1'b0, "R7 comb path a", 32'(out_vec[0]), 0);
        in_vec = 4'b0010; #1;
        check(out_vec[0] == 1'b1, "R7 comb path b", 32'(out_vec[0]), 1);
        // R7: a write is visible right after its edge
        in_vec = 4'b0001;
        wr(POLR, 8'b0000_0100);
        check(out_vec[0] == 1'b1, "R7 write visible", 32'(out_vec[0]), 1);

        // R8: unused high bits are dropped
        wr(POLR, 8'hFF);
        cfg_raddr = AW'(POLR); #1;
        check(cfg_rdata == 8'h07, "R8 polarity truncation", 32'(cfg_rdata), 32'h07);
        wr(NP + 2, 8'hFF);
        cfg_raddr = AW'(NP + 2); #1;
        check(cfg_rdata == 8'h3F, "R8 or-row truncation", 32'(cfg_rdata), 32'h3F);
        readback_all("R8 readback");

        // R9: unmapped writes change nothing
        wr(ROWS, 8'hFF);
        wr(15, 8'hA5);
        readback_all("R9 unmapped write");
        sweep("R9 outputs after unmapped write");

        // R10: idle port with moving address/data
        for (int r = 0; r < ROWS; r++) begin
            @(negedge clk);
            cfg_addr  = AW'(r);
            cfg_wdata = 8'hFF;
        end
        @(negedge clk);
        readback_all("R10 idle port");
        sweep("R10 outputs with idle port");

        // Random configurations: R2 R5 R6 R8 together
        clear_all();
        for (int n = 0; n < 40; n++) begin
            for (int p = 0; p < NP; p++) wr(p, W'($urandom & $urandom));
            for (int k = 0; k < NO; k++) wr(NP + k, W'($urandom));
            wr(POLR, W'($urandom));
            sweep("R2/R5/R6 random sum of products");
            cfg_raddr = AW'(n % ROWS); #1;
            check(cfg_rdata == shadow_row(n % ROWS), "R8 random readback",
                  32'(cfg_rdata), 32'(shadow_row(n % ROWS)));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule